// File: doc/BRIEF.md
# Backplane Memory Window Address Decoder

This block decides whether a memory board answers a backplane bus cycle. At the rising edge of the address strobe it captures the multiplexed byte address and the I/O page strobe. It then checks the captured address against a window. The window starts at a strap-selected boundary of one row (65,536 words) and spans either four or eight rows. An addressing-mode strap picks the full 22-bit space or the narrow 18-bit space. In narrow mode the address bits above the narrow width are ignored.

Cycles marked with the I/O page strobe are refused, which leaves the top of the address space to peripherals. A reclaim strap lets the lower half of that page answer as ordinary memory. The outputs are a select flag, the row index, the word offset inside the row and the byte-select bit. They stay constant while the strobe is held, and the select flag clears once the strobe is released. Each stored word is 18 bits: two bytes with one parity bit per byte. The decoder itself only selects the word and the byte.

Top module: `bus_window_decoder`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), hit_o, row_o, word_ofs_o and byte_sel_o are all zero.
- R2: The address and the I/O page strobe are captured at the first clock edge that sees strb_i high after it was low. Outputs for that cycle appear at the following clock edge, provided strb_i is still high.
- R3: While strb_i stays high, a change on bus_addr_i or io_sel_i has no effect on any output. hit_o clears at the first clock edge that samples strb_i low.
- R4: With unit = effective address bits [ADR_W-1 : OFS_W+1] and start = base_cfg_i, hit requires start <= unit < start + rows. The comparison is done without wraparound, so any part of the window beyond the top of the space is dropped.
- R5: big_board_i = 0 gives a window of 2^ROW_W/2 rows (4 by default). big_board_i = 1 gives 2^ROW_W rows (8 by default).
- R6: wide_mode_i = 1 uses all ADR_W address bits. wide_mode_i = 0 treats bits ADR_W-1 down to NARROW_W as zero before any comparison.
- R7: On a hit, row_o = unit - start. On every decoded cycle, word_ofs_o = address bits [OFS_W:1] and byte_sel_o = address bit 0.
- R8: A cycle captured with io_sel_i = 1 never hits when reclaim_i = 0.
- R9: With reclaim_i = 1, an I/O cycle whose address bit IO_LOG2-1 is 0 (the lower half of the page) hits exactly as a memory cycle at that address would.
- R10: An I/O cycle whose address bit IO_LOG2-1 is 1 (the upper half of the page) never hits, whatever the value of reclaim_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strb_i | input | 1 | Address strobe; its rising edge starts a cycle |
| bus_addr_i | input | ADR_W | Multiplexed byte address |
| io_sel_i | input | 1 | I/O page strobe for the cycle |
| base_cfg_i | input | ADR_W-OFS_W-1 | Window start, in rows |
| big_board_i | input | 1 | 0: half-size board, 1: full-size board |
| wide_mode_i | input | 1 | 1: full-width addressing, 0: narrow addressing |
| reclaim_i | input | 1 | Lets the lower half of the I/O page answer as memory |
| hit_o | output | 1 | Board selected for this cycle |
| row_o | output | ROW_W | Selected row |
| word_ofs_o | output | OFS_W | Word offset within the row |
| byte_sel_o | output | 1 | Byte select (address bit 0) |

## Verification
The bench builds the decoder with an 8-bit address, a 2-bit word offset, a 6-bit narrow width and an 8-byte I/O page. It keeps the default of 8 rows. With these values the 5-bit start field, both board sizes and both addressing modes can all be swept against every one of the 256 addresses. That sweep reaches windows clipped at the top of either space, and narrow addresses whose ignored upper bits are set. Every configuration also receives I/O cycles at each page address, with and without reclaim.

// File: rtl/addr_dec_pkg.sv
// Shared definitions for the memory window decoder.
// Assumes: straps are steady while a bus cycle is in progress.
package addr_dec_pkg;
    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } addr_mode_e;

    typedef enum logic {
        SIZE_HALF = 1'b0,
        SIZE_FULL = 1'b1
    } board_size_e;
endpackage

// File: rtl/wdec_capture.sv
// Detects the rising edge of the address strobe, latches address and I/O
// strobe there, and flags the next cycle as the decode cycle.
// Assumes: strb_i is synchronous to clk.
module wdec_capture #(
    parameter int ADR_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strb_i,
    input  logic [ADR_W-1:0] addr_i,
    input  logic             io_i,
    output logic [ADR_W-1:0] cap_addr_o,
    output logic             cap_io_o,
    output logic             pend_o
);
    logic strb_q;
    logic rise;

    // Edge detect on the strobe.
    always_comb rise = strb_i & ~strb_q;

    // Capture address and I/O strobe on the strobe rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_q     <= 1'b0;
            cap_addr_o <= '0;
            cap_io_o   <= 1'b0;
            pend_o     <= 1'b0;
        end else begin
            strb_q <= strb_i;
            pend_o <= rise;
            if (rise) begin
                cap_addr_o <= addr_i;
                cap_io_o   <= io_i;
            end
        end
    end

    AST_CAPTURE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb_i) |=> (cap_addr_o == $past(addr_i)) && (cap_io_o == $past(io_i))); // R2
endmodule

// File: rtl/wdec_window.sv
// Combinational window compare: masks the address for the addressing mode,
// compares the row unit against start and size, and derives row and offset.
// Assumes: ROW_W <= ADR_W-OFS_W-1 and NARROW_W > OFS_W.
module wdec_window
    import addr_dec_pkg::*;
#(
    parameter int ADR_W    = 22,
    parameter int OFS_W    = 16,
    parameter int NARROW_W = 18,
    parameter int ROW_W    = 3
) (
    input  logic [ADR_W-1:0]         addr_i,
    input  logic [ADR_W-OFS_W-2:0]   start_i,
    input  logic                     big_i,
    input  logic                     wide_i,
    output logic                     in_win_o,
    output logic [ROW_W-1:0]         row_o,
    output logic [OFS_W-1:0]         ofs_o,
    output logic                     bsel_o
);
    localparam int UNIT_W   = ADR_W - OFS_W - 1;
    localparam int ROWS_MAX = 1 << ROW_W;

    logic [ADR_W-1:0]  eff;
    logic [UNIT_W-1:0] unit;
    logic [UNIT_W:0]   span;
    logic [UNIT_W:0]   limit;
    logic [UNIT_W-1:0] diff;

    // Mode masking; a narrow width at or above the full width masks nothing.
    generate
        if (NARROW_W >= ADR_W) begin : g_no_mask
            always_comb eff = addr_i;
        end else begin : g_mask
            localparam logic [ADR_W-1:0] NMASK =
                {{(ADR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
            always_comb eff = (addr_mode_e'(wide_i) == MODE_WIDE) ? addr_i : (addr_i & NMASK);
        end
    endgenerate

    // Window bounds, one bit wider so the top end never wraps.
    always_comb begin
        unit     = eff[ADR_W-1:OFS_W+1];
        span     = (board_size_e'(big_i) == SIZE_FULL) ? (UNIT_W+1)'(ROWS_MAX)
                                                       : (UNIT_W+1)'(ROWS_MAX/2);
        limit    = {1'b0, start_i} + span;
        in_win_o = ({1'b0, unit} >= {1'b0, start_i}) && ({1'b0, unit} < limit);
        diff     = unit - start_i;
        row_o    = diff[ROW_W-1:0];
        ofs_o    = eff[OFS_W:1];
        bsel_o   = eff[0];
    end
endmodule

// File: rtl/wdec_io_veto.sv
// I/O page veto: refuses I/O cycles, except the lower half of the page when
// reclaim is strapped on.
// Assumes: the I/O strobe alone marks the page; IO_LOG2 is the page size in bytes (log2).
module wdec_io_veto #(
    parameter int ADR_W   = 22,
    parameter int IO_LOG2 = 13
) (
    input  logic [ADR_W-1:0] addr_i,
    input  logic             io_i,
    input  logic             reclaim_i,
    output logic             allow_o
);
    // Upper half of the page is always refused.
    always_comb allow_o = !io_i || (reclaim_i && !addr_i[IO_LOG2-1]);
endmodule

// File: rtl/bus_window_decoder.sv
// Top of the memory window decoder. Captures the cycle, decodes it one
// clock later and holds the result while the strobe stays high.
// Assumes: straps (base, size, mode, reclaim) change only between cycles.
module bus_window_decoder #(
    parameter int ADR_W    = 22,
    parameter int OFS_W    = 16,
    parameter int NARROW_W = 18,
    parameter int IO_LOG2  = 13,
    parameter int ROW_W    = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strb_i,
    input  logic [ADR_W-1:0]       bus_addr_i,
    input  logic                   io_sel_i,
    input  logic [ADR_W-OFS_W-2:0] base_cfg_i,
    input  logic                   big_board_i,
    input  logic                   wide_mode_i,
    input  logic                   reclaim_i,
    output logic                   hit_o,
    output logic [ROW_W-1:0]       row_o,
    output logic [OFS_W-1:0]       word_ofs_o,
    output logic                   byte_sel_o
);
    localparam int ROWS_MAX = 1 << ROW_W;

    logic [ADR_W-1:0] cap_addr;
    logic             cap_io;
    logic             pend;
    logic             in_win;
    logic             allow;
    logic [ROW_W-1:0] row_d;
    logic [OFS_W-1:0] ofs_d;
    logic             bsel_d;

    wdec_capture #(.ADR_W(ADR_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .strb_i(strb_i), .addr_i(bus_addr_i),
        .io_i(io_sel_i), .cap_addr_o(cap_addr), .cap_io_o(cap_io), .pend_o(pend)
    );

    wdec_window #(.ADR_W(ADR_W), .OFS_W(OFS_W), .NARROW_W(NARROW_W), .ROW_W(ROW_W)) u_window (
        .addr_i(cap_addr), .start_i(base_cfg_i), .big_i(big_board_i),
        .wide_i(wide_mode_i), .in_win_o(in_win), .row_o(row_d),
        .ofs_o(ofs_d), .bsel_o(bsel_d)
    );

    wdec_io_veto #(.ADR_W(ADR_W), .IO_LOG2(IO_LOG2)) u_veto (
        .addr_i(cap_addr), .io_i(cap_io), .reclaim_i(reclaim_i), .allow_o(allow)
    );

    // Output register: load on the decode cycle, hold while strobed, clear hit on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_o      <= 1'b0;
            row_o      <= '0;
            word_ofs_o <= '0;
            byte_sel_o <= 1'b0;
        end else if (!strb_i) begin
            hit_o <= 1'b0;
        end else if (pend) begin
            hit_o      <= in_win && allow;
            row_o      <= row_d;
            word_ofs_o <= ofs_d;
            byte_sel_o <= bsel_d;
        end
    end

    AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> $past(strb_i)); // R3
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && $past(hit_o)) |-> ($stable(row_o) && $stable(word_ofs_o) && $stable(byte_sel_o))); // R3
    AST_SMALL_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && !big_board_i) |-> (int'(row_o) < ROWS_MAX/2)); // R5
    AST_UPPER_IO_VETO: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> !(cap_io && cap_addr[IO_LOG2-1])); // R10
endmodule

// File: tb/bus_window_decoder_bench.sv
`timescale 1ns/1ps
module bus_window_decoder_bench;
    localparam int AW = 8;
    localparam int OW = 2;
    localparam int NW = 6;
    localparam int IL = 3;
    localparam int RW = 3;
    localparam int UW = AW - OW - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strb = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          io = 1'b0;
    logic [UW-1:0] base = '0;
    logic          big = 1'b0;
    logic          wide = 1'b1;
    logic          recl = 1'b0;
    logic          hit;
    logic [RW-1:0] row;
    logic [OW-1:0] ofs;
    logic          bsel;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bus_window_decoder #(.ADR_W(AW), .OFS_W(OW), .NARROW_W(NW), .IO_LOG2(IL), .ROW_W(RW)) u_bus_window_decoder (
        .clk(clk), .rst_n(rst_n), .strb_i(strb), .bus_addr_i(addr), .io_sel_i(io),
        .base_cfg_i(base), .big_board_i(big), .wide_mode_i(wide), .reclaim_i(recl),
        .hit_o(hit), .row_o(row), .word_ofs_o(ofs), .byte_sel_o(bsel)
    );

    function automatic bit exp_hit(int a, int st, bit bg, bit wd, bit iop, bit rc);
        int eff  = wd ? a : (a & ((1 << NW) - 1));
        int unit = eff >> (OW + 1);
        int span = bg ? (1 << RW) : (1 << RW) / 2;
        bit inw  = (unit >= st) && (unit < st + span);
        bit veto = iop && !(rc && (((a >> (IL - 1)) & 1) == 0));
        return inw && !veto;
    endfunction

    task automatic check(bit ok, string req, string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s", req, msg);
        end
    endtask

    // One bus cycle: raise strobe, sample after the decode edge, release.
    task automatic txn(int a, bit iop, string req);
        bit eh;
        int eff;
        int er;
        @(negedge clk);
        addr = AW'(a); io = iop; strb = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        eh  = exp_hit(a, int'(base), big, wide, iop, recl);
        eff = wide ? a : (a & ((1 << NW) - 1));
        er  = ((eff >> (OW + 1)) - int'(base)) & ((1 << RW) - 1);
        check(hit == eh, req, $sformatf("hit act=%0d exp=%0d a=%0d io=%0d base=%0d big=%0d wide=%0d recl=%0d",
              hit, eh, a, iop, base, big, wide, recl));
        check(ofs == OW'(a >> 1) && bsel == a[0], "R7", $sformatf("ofs/bsel act=%0d/%0d exp=%0d/%0d",
              ofs, bsel, (a >> 1) & ((1 << OW) - 1), a & 1));
        if (eh) check(int'(row) == er, "R7", $sformatf("row act=%0d exp=%0d a=%0d", row, er, a));
        strb = 1'b0;
        @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=expired exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(hit == 0 && row == 0 && ofs == 0 && bsel == 0, "R1",
              $sformatf("reset act=%0d/%0d/%0d/%0d exp=0/0/0/0", hit, row, ofs, bsel));
        rst_n = 1'b1;

        // R2: outputs not valid at the capture edge, valid one edge later.
        base = 5'd2; big = 1; wide = 1; recl = 0;
        @(negedge clk); addr = 8'd20; io = 0; strb = 1;
        @(posedge clk); @(negedge clk);
        check(hit == 0, "R2", $sformatf("early hit act=%0d exp=0", hit));
        @(posedge clk); @(negedge clk);
        check(hit == 1 && row == 0, "R2", $sformatf("decode act=%0d row=%0d exp=1 row=0", hit, row));
        // R3: address change while held has no effect.
        addr = 8'd3; io = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(hit == 1 && row == 0 && ofs == 2'd2 && bsel == 0, "R3",
              $sformatf("hold act=%0d/%0d/%0d/%0d exp=1/0/2/0", hit, row, ofs, bsel));
        strb = 0;
        @(posedge clk); @(negedge clk);
        check(hit == 0, "R3", $sformatf("release act=%0d exp=0", hit));

        // R4 R5 R6 R7: full sweep of memory cycles.
        for (int st = 0; st < (1 << UW); st++)
            for (int bg = 0; bg < 2; bg++)
                for (int wd = 0; wd < 2; wd++) begin
                    base = UW'(st); big = bg[0]; wide = wd[0]; recl = 0;
                    for (int a = 0; a < (1 << AW); a++)
                        txn(a, 1'b0, wd ? "R4" : "R6");
                end

        // R8 R9 R10: I/O page cycles with and without reclaim.
        for (int st = 0; st < (1 << UW); st++)
            for (int bg = 0; bg < 2; bg++)
                for (int wd = 0; wd < 2; wd++)
                    for (int rc = 0; rc < 2; rc++) begin
                        base = UW'(st); big = bg[0]; wide = wd[0]; recl = rc[0];
                        for (int p = 0; p < (1 << IL); p++) begin
                            int pa = wd ? ((1 << AW) - (1 << IL) + p)
                                        : ((3 << NW) | ((1 << NW) - (1 << IL) + p));
                            txn(pa, 1'b1, (p >= (1 << (IL - 1))) ? "R10" : (rc ? "R9" : "R8"));
                        end
                    end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule